// File: doc/BRIEF.md
# Shadow Register Save/Restore Unit

This block keeps one hidden copy of a handful of processor registers and moves values between that copy and the live registers when the core signals an event. There are two separate groups. The working group holds the four lowest working registers and five arithmetic status flags. It is saved on a push-shadow event and brought back on a pop-shadow event. The loop group holds the loop start address, the loop end address and the loop count. It is saved when a loop starts and brought back when a loop ends.

The unit has no read or write path to its copies other than these events. A restore is registered. In the cycle after the triggering event, the unit raises a one-cycle write strobe and drives the saved data. Each copy is one level deep, so a later save replaces an earlier one that was never restored.

Top module: `shadow_save_restore`

## Requirements
- R1: During and after reset, all write strobes are low and all restore data outputs are zero. The copies are cleared, so a pop after reset restores zeros.
- R2: A push-shadow event captures `wreg_i`, with W0 in bits [15:0] up to W3 in bits [63:48]. It also captures the status flags at bit positions C=0, Z=1, OV=2, N=3 and DC=8.
- R3: For a pop-shadow event in cycle k, `w_we_o` is high in cycle k+1 only. In that cycle `w_o` carries the four words from the last capture.
- R4: `sr_we_o` is the per-bit mask 0x010F during a working-group restore and zero at all other times. `sr_o` carries the saved flags at those positions and zero elsewhere, so status bits that are not shadowed are never written.
- R5: A loop-start event captures the start address, end address and count. For a loop-end event in cycle k, `loop_we_o` is high in cycle k+1 only, with the saved loop values on the loop data outputs.
- R6: A second push before a pop replaces the first capture. The pop returns the later values.
- R7: Events of one group never capture into, strobe or change the outputs of the other group.
- R8: A save and a restore in the same cycle on one group restore the contents held before that cycle and capture the new inputs.
- R9: With no restore event, the strobes stay low and the restore data outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_sh_i | input | 1 | Save working group |
| pop_sh_i | input | 1 | Restore working group |
| loop_start_i | input | 1 | Save loop group |
| loop_end_i | input | 1 | Restore loop group |
| wreg_i | input | 64 | Live W3..W0 |
| status_i | input | 16 | Live status register |
| lstart_i | input | 23 | Live loop start address |
| lend_i | input | 23 | Live loop end address |
| lcount_i | input | 14 | Live loop count |
| w_we_o | output | 1 | Working register write strobe |
| w_o | output | 64 | Restored W3..W0 |
| sr_we_o | output | 16 | Per-bit status write mask |
| sr_o | output | 16 | Restored status flags |
| loop_we_o | output | 1 | Loop register write strobe |
| lstart_o | output | 23 | Restored loop start address |
| lend_o | output | 23 | Restored loop end address |
| lcount_o | output | 14 | Restored loop count |

## Verification
A capture takes effect at the clock edge that samples the save event. It becomes visible only through a later restore, whose strobe and data show up right after the edge that samples the restore event. The bench drives each event at a falling edge and reads the outputs shortly after the next rising edge. That reading falls in the single cycle in which a strobe should be high. The row that follows reads the same outputs one cycle later, which confirms the strobe has dropped and the data is holding.

// File: rtl/shadow_save_restore.sv
module shadow_save_restore #(
  parameter int DATA_W = 16,
  parameter int NUM_W = 4,
  parameter int SR_W = 16,
  parameter logic [SR_W-1:0] FLAG_MASK = 'h010F,
  parameter int ADDR_W = 23,
  parameter int CNT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_sh_i,
  input  logic                    pop_sh_i,
  input  logic                    loop_start_i,
  input  logic                    loop_end_i,
  input  logic [NUM_W*DATA_W-1:0] wreg_i,
  input  logic [SR_W-1:0]         status_i,
  input  logic [ADDR_W-1:0]       lstart_i,
  input  logic [ADDR_W-1:0]       lend_i,
  input  logic [CNT_W-1:0]        lcount_i,
  output logic                    w_we_o,
  output logic [NUM_W*DATA_W-1:0] w_o,
  output logic [SR_W-1:0]         sr_we_o,
  output logic [SR_W-1:0]         sr_o,
  output logic                    loop_we_o,
  output logic [ADDR_W-1:0]       lstart_o,
  output logic [ADDR_W-1:0]       lend_o,
  output logic [CNT_W-1:0]        lcount_o
);
  localparam int WV_W = NUM_W * DATA_W;

  logic [WV_W-1:0]   w_sh;
  logic [SR_W-1:0]   sr_sh;
  logic [ADDR_W-1:0] ls_sh, le_sh;
  logic [CNT_W-1:0]  lc_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_sh   <= '0;
      sr_sh  <= '0;
      w_we_o <= 1'b0;
      w_o    <= '0;
      sr_o   <= '0;
    end else begin
      w_we_o <= pop_sh_i;
      if (pop_sh_i) begin
        w_o  <= w_sh;
        sr_o <= sr_sh;
      end
      if (push_sh_i) begin
        w_sh  <= wreg_i;
        sr_sh <= status_i & FLAG_MASK;
      end
    end
  end

  assign sr_we_o = {SR_W{w_we_o}} & FLAG_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_sh     <= '0;
      le_sh     <= '0;
      lc_sh     <= '0;
      loop_we_o <= 1'b0;
      lstart_o  <= '0;
      lend_o    <= '0;
      lcount_o  <= '0;
    end else begin
      loop_we_o <= loop_end_i;
      if (loop_end_i) begin
        lstart_o <= ls_sh;
        lend_o   <= le_sh;
        lcount_o <= lc_sh;
      end
      if (loop_start_i) begin
        ls_sh <= lstart_i;
        le_sh <= lend_i;
        lc_sh <= lcount_i;
      end
    end
  end

  a_r3_pop_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pop_sh_i |=> w_we_o);
  a_r9_w_strobe_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
    w_we_o |-> $past(pop_sh_i));
  a_r4_sr_unshadowed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & ~FLAG_MASK) == '0);
  a_r5_loop_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end_i |=> loop_we_o);
  a_r7_loop_events_no_w_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_end_i && !pop_sh_i) |=> !w_we_o);
  a_r9_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_end_i |=> $stable(lstart_o) && $stable(lcount_o));
endmodule

// File: tb/shadow_save_restore_tb_top.sv
module shadow_save_restore_tb_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] MASK = 16'h010F;
  localparam logic [63:0] JUNK = 64'hAAAA_AAAA_AAAA_AAAA;

  typedef struct packed {
    logic push, pop, ls, le;
    logic [63:0] w;
    logic [15:0] sr;
    logic [22:0] ds, de;
    logic [13:0] dc;
    logic [3:0]  tag;
    logic        e_wwe;
    logic [63:0] e_w;
    logic [15:0] e_sr;
    logic        e_lwe;
    logic [22:0] e_ds, e_de;
    logic [13:0] e_dc;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1,1'b0,1'b0,1'b0, 64'h1111_2222_3333_4444, 16'hFFFF, 23'h0, 23'h0, 14'h0, 4'd2,
      1'b0, 64'h0, 16'h0, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b0,1'b0,1'b1,1'b0, JUNK, 16'hFFFF, 23'h000100, 23'h000200, 14'h5, 4'd5,
      1'b0, 64'h0, 16'h0, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b0,1'b1,1'b0,1'b0, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd3,
      1'b1, 64'h1111_2222_3333_4444, 16'h010F, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b0,1'b0,1'b0,1'b0, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd9,
      1'b0, 64'h1111_2222_3333_4444, 16'h010F, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b1,1'b0,1'b0,1'b0, 64'h5555_5555_5555_5555, 16'h0105, 23'h0, 23'h0, 14'h0, 4'd6,
      1'b0, 64'h1111_2222_3333_4444, 16'h010F, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b1,1'b0,1'b0,1'b0, 64'h6666_6666_6666_6666, 16'h000A, 23'h0, 23'h0, 14'h0, 4'd6,
      1'b0, 64'h1111_2222_3333_4444, 16'h010F, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b0,1'b1,1'b0,1'b0, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd6,
      1'b1, 64'h6666_6666_6666_6666, 16'h000A, 1'b0, 23'h0, 23'h0, 14'h0},
    '{1'b0,1'b0,1'b0,1'b1, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd5,
      1'b0, 64'h6666_6666_6666_6666, 16'h000A, 1'b1, 23'h000100, 23'h000200, 14'h5},
    '{1'b1,1'b1,1'b0,1'b0, 64'h7777_7777_7777_7777, 16'hF0F0, 23'h0, 23'h0, 14'h0, 4'd8,
      1'b1, 64'h6666_6666_6666_6666, 16'h000A, 1'b0, 23'h000100, 23'h000200, 14'h5},
    '{1'b0,1'b1,1'b0,1'b0, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd8,
      1'b1, 64'h7777_7777_7777_7777, 16'h0000, 1'b0, 23'h000100, 23'h000200, 14'h5},
    '{1'b0,1'b0,1'b1,1'b1, JUNK, 16'h0, 23'h0ABCDE, 23'h0ABCFF, 14'h3FFF, 4'd8,
      1'b0, 64'h7777_7777_7777_7777, 16'h0000, 1'b1, 23'h000100, 23'h000200, 14'h5},
    '{1'b0,1'b0,1'b0,1'b1, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd5,
      1'b0, 64'h7777_7777_7777_7777, 16'h0000, 1'b1, 23'h0ABCDE, 23'h0ABCFF, 14'h3FFF},
    '{1'b1,1'b0,1'b1,1'b0, 64'h8888_8888_8888_8888, 16'hFFFF, 23'h0, 23'h0, 14'h0, 4'd7,
      1'b0, 64'h7777_7777_7777_7777, 16'h0000, 1'b0, 23'h0ABCDE, 23'h0ABCFF, 14'h3FFF},
    '{1'b0,1'b0,1'b0,1'b1, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd7,
      1'b0, 64'h7777_7777_7777_7777, 16'h0000, 1'b1, 23'h0, 23'h0, 14'h0},
    '{1'b0,1'b1,1'b0,1'b0, JUNK, 16'h0, 23'h0, 23'h0, 14'h0, 4'd7,
      1'b1, 64'h8888_8888_8888_8888, 16'h010F, 1'b0, 23'h0, 23'h0, 14'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_sh, pop_sh, loop_start, loop_end;
  logic [63:0] wreg;
  logic [15:0] status;
  logic [22:0] lstart, lend;
  logic [13:0] lcount;
  logic        w_we, loop_we;
  logic [63:0] w_out;
  logic [15:0] sr_we, sr_out;
  logic [22:0] lstart_out, lend_out;
  logic [13:0] lcount_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  shadow_save_restore dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_sh_i(push_sh), .pop_sh_i(pop_sh),
    .loop_start_i(loop_start), .loop_end_i(loop_end),
    .wreg_i(wreg), .status_i(status),
    .lstart_i(lstart), .lend_i(lend), .lcount_i(lcount),
    .w_we_o(w_we), .w_o(w_out), .sr_we_o(sr_we), .sr_o(sr_out),
    .loop_we_o(loop_we), .lstart_o(lstart_out), .lend_o(lend_out), .lcount_o(lcount_out)
  );

  function automatic string req_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_sh = 1'b0; pop_sh = 1'b0; loop_start = 1'b0; loop_end = 1'b0;
    wreg = JUNK; status = 16'h0; lstart = '0; lend = '0; lcount = '0;
  endtask

  task automatic chk_zero(input string req);
    chk(req, "w_we", {63'h0, w_we}, 64'h0);
    chk(req, "w_o", w_out, 64'h0);
    chk(req, "sr_we", {48'h0, sr_we}, 64'h0);
    chk(req, "sr_o", {48'h0, sr_out}, 64'h0);
    chk(req, "loop_we", {63'h0, loop_we}, 64'h0);
    chk(req, "lstart", {41'h0, lstart_out}, 64'h0);
    chk(req, "lcount", {50'h0, lcount_out}, 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    chk_zero("R1");
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      push_sh = ROWS[i].push; pop_sh = ROWS[i].pop;
      loop_start = ROWS[i].ls; loop_end = ROWS[i].le;
      wreg = ROWS[i].w; status = ROWS[i].sr;
      lstart = ROWS[i].ds; lend = ROWS[i].de; lcount = ROWS[i].dc;
      @(posedge clk);
      #(CLK_P/5);
      chk(req_name(ROWS[i].tag), "w_we", {63'h0, w_we}, {63'h0, ROWS[i].e_wwe});
      chk(req_name(ROWS[i].tag), "w_o", w_out, ROWS[i].e_w);
      chk("R4", "sr_we", {48'h0, sr_we}, {48'h0, ROWS[i].e_wwe ? MASK : 16'h0});
      chk(req_name(ROWS[i].tag), "sr_o", {48'h0, sr_out}, {48'h0, ROWS[i].e_sr});
      chk(req_name(ROWS[i].tag), "loop_we", {63'h0, loop_we}, {63'h0, ROWS[i].e_lwe});
      chk(req_name(ROWS[i].tag), "lstart", {41'h0, lstart_out}, {41'h0, ROWS[i].e_ds});
      chk(req_name(ROWS[i].tag), "lend", {41'h0, lend_out}, {41'h0, ROWS[i].e_de});
      chk(req_name(ROWS[i].tag), "lcount", {50'h0, lcount_out}, {50'h0, ROWS[i].e_dc});
    end

    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    chk("R9", "w_we idle", {63'h0, w_we}, 64'h0);
    chk("R9", "w_o hold", w_out, 64'h8888_8888_8888_8888);

    @(negedge clk);
    push_sh = 1'b1; loop_start = 1'b1;
    wreg = 64'h9999_9999_9999_9999; status = 16'hFFFF;
    lstart = 23'h12345; lend = 23'h23456; lcount = 14'h77;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_zero("R1");
    rst_n = 1'b1;
    pop_sh = 1'b1; loop_end = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R1", "w_we after reset", {63'h0, w_we}, 64'h1);
    chk("R1", "w_o cleared", w_out, 64'h0);
    chk("R1", "sr_o cleared", {48'h0, sr_out}, 64'h0);
    chk("R1", "lstart cleared", {41'h0, lstart_out}, 64'h0);
    chk("R1", "lcount cleared", {50'h0, lcount_out}, 64'h0);

    finish_run();
  end
endmodule